// File: doc/BRIEF.md
# Reference Switchover Controller with Phase Build-Out

This block picks one of several reference clocks to lock to. Whenever it changes the active reference, it decides whether to hide the phase step between the old and new reference. Each reference has a small selection priority held in its own profile register. A separate phase-master threshold register decides which references count as phase masters.

Arbitration always prefers the numerically lowest priority value among the references flagged valid. An automatic switch happens when the active reference loses its valid flag, or when a valid reference with a strictly better priority appears. An external request forces a move to the current arbitration winner. When the new reference is not a phase master, the block performs a build-out: it latches the supplied phase-error word as an offset, and later phase errors have that offset subtracted. A switch to a phase master clears the offset. If no reference is valid when the active one is lost, the block enters holdover and keeps its last selection.

Top module: `ref_switch_ctrl`

## Requirements
- R1: After reset, `sel_ref` is 0, `holdover` is 1, `switch_pulse` and `buildout_pulse` are 0, and `phase_offset` is 0. The threshold and every reference priority reset to 0.
- R2: The arbitration winner is the valid reference with the lowest priority value. Ties go to the lowest reference index.
- R3: Outside holdover, a switch to the winner happens at the clock edge where the active reference's `ref_valid` bit is low and some reference is valid. A switch also happens at the edge where the winner's priority is strictly lower than the active reference's priority. An equal priority causes no automatic switch.
- R4: With `switch_req` high and some reference valid, the block switches to the winner if the winner differs from the active reference or holdover is set. This includes the case of an equal priority.
- R5: When the active reference is lost and no reference is valid, `holdover` goes to 1 and `sel_ref` keeps its value. While in holdover, the first edge with any valid reference switches to the winner and clears `holdover`.
- R6: A reference is a phase master when its priority value is numerically lower than the threshold. A switch raises `buildout_pulse` only if the new reference is not a phase master.
- R7: With the threshold at its reset value 0, every switch is a build-out.
- R8: On a build-out switch, `phase_offset` takes the `phase_err_in` value present at that edge. On a switch without build-out, it becomes 0. Otherwise it holds its value.
- R9: `phase_err_out` equals `phase_err_in - phase_offset`, modulo 2^PHASE_W, with no clock delay.
- R10: `prio_we` writes `prio_wdata` into the profile of reference `prio_widx`, and `thr_we` writes `thr_wdata` into the threshold. The new value is used from the next edge onwards.
- R11: `switch_pulse` is high for the one cycle that follows each switch edge. `sel_ref` shows the new reference in that same cycle, and `buildout_pulse` is only ever high together with `switch_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_valid | input | NUM_REF | Per-reference valid flags from the monitors |
| switch_req | input | 1 | Forces a move to the arbitration winner |
| prio_we | input | 1 | Profile priority write strobe |
| prio_widx | input | IDX_W | Reference whose priority is written |
| prio_wdata | input | 3 | Priority value to write (lower is better) |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 3 | Phase-master threshold value |
| phase_err_in | input | PHASE_W | Raw phase-error word from the detector |
| sel_ref | output | IDX_W | Active reference index |
| holdover | output | 1 | No reference is in use |
| switch_pulse | output | 1 | One-cycle pulse after a switch |
| buildout_pulse | output | 1 | One-cycle pulse after a build-out switch |
| phase_offset | output | PHASE_W | Latched build-out offset |
| phase_err_out | output | PHASE_W | Phase error with the offset removed |

## Verification
A wrong selection or holdover state shows on `sel_ref` and `holdover` one cycle after the edge that caused it. The next valid-flag change then compounds it, because the trigger rules read the active index. A wrong master decision shows on `buildout_pulse` in the same cycle as `switch_pulse`. It also shows on `phase_offset` and `phase_err_out` from then until the next switch, so a mis-latched offset stays visible for many cycles. Random valid patterns and register writes are compared every cycle against a bench model. Directed sequences cover ties, forced moves, a threshold of zero, phase masters and holdover.

// File: rtl/ref_switch_pkg.sv
package ref_switch_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  // Phase master: priority value strictly below the threshold.
  function automatic logic is_phase_master(input prio_t prio, input prio_t thr);
    return prio < thr;
  endfunction

  // Candidate a beats b when its value is strictly lower.
  function automatic logic prio_beats(input prio_t a, input prio_t b);
    return a < b;
  endfunction
endpackage

// File: rtl/ref_profile_regs.sv
module ref_profile_regs
  import ref_switch_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prio_we,
  input  logic [IDX_W-1:0] prio_widx,
  input  prio_t            prio_wdata,
  input  logic             thr_we,
  input  prio_t            thr_wdata,
  output prio_t            prio_q [NUM_REF],
  output prio_t            thr_q
);
  for (genvar g = 0; g < NUM_REF; g++) begin : g_prof
    logic hit;
    assign hit = prio_we && (prio_widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio_q[g] <= '0;
      else if (hit) prio_q[g] <= prio_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_we) thr_q <= thr_wdata;
  end

  AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (thr_q == $past(thr_wdata))); // R10
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_we |=> $stable(thr_q)); // R10
endmodule

// File: rtl/ref_arbiter.sv
module ref_arbiter
  import ref_switch_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_REF-1:0] ref_valid,
  input  prio_t              prio_q [NUM_REF],
  output logic [IDX_W-1:0]   win_idx,
  output prio_t              win_prio,
  output logic               win_found
);
  // Scan upward: strict compare keeps the lowest index on ties.
  always_comb begin
    win_idx   = '0;
    win_prio  = '0;
    win_found = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (ref_valid[i] && (!win_found || prio_beats(prio_q[i], win_prio))) begin
        win_idx   = IDX_W'(i);
        win_prio  = prio_q[i];
        win_found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_switch_seq.sv
module ref_switch_seq
  import ref_switch_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_valid,
  input  logic               switch_req,
  input  prio_t              prio_q [NUM_REF],
  input  prio_t              thr_q,
  input  logic [IDX_W-1:0]   win_idx,
  input  prio_t              win_prio,
  input  logic               win_found,
  output logic [IDX_W-1:0]   sel_q,
  output logic               hold_q,
  output logic               switch_q,
  output logic               buildout_q,
  output logic               switch_evt,
  output logic               buildout_evt
);
  logic cur_valid, lost_evt, better_evt, forced_evt, acquire_evt, enter_hold;

  assign cur_valid    = ref_valid[sel_q];
  assign lost_evt     = !hold_q && !cur_valid;
  assign better_evt   = !hold_q && cur_valid && win_found &&
                        prio_beats(win_prio, prio_q[sel_q]);
  assign forced_evt   = switch_req && win_found && (hold_q || (win_idx != sel_q));
  assign acquire_evt  = hold_q && win_found;
  assign switch_evt   = win_found && (lost_evt || better_evt || forced_evt || acquire_evt);
  assign enter_hold   = lost_evt && !win_found;
  assign buildout_evt = switch_evt && !is_phase_master(win_prio, thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      hold_q     <= 1'b1;
      switch_q   <= 1'b0;
      buildout_q <= 1'b0;
    end else begin
      switch_q   <= switch_evt;
      buildout_q <= buildout_evt;
      if (switch_evt) begin
        sel_q  <= win_idx;
        hold_q <= 1'b0;
      end else if (enter_hold) begin
        hold_q <= 1'b1;
      end
    end
  end

  AST_LOST_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !ref_valid[sel_q]) |=> (switch_q || hold_q)); // R3
  AST_HOLD_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !(|ref_valid)) |=> (hold_q && $stable(sel_q))); // R5
  AST_BUILDOUT_IN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    buildout_q |-> switch_q); // R11
  AST_ZERO_THR_BUILDOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_evt && thr_q == '0) |=> buildout_q); // R7
  AST_NO_SWITCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_evt |=> $stable(sel_q)); // R11
endmodule

// File: rtl/phase_offset_unit.sv
module phase_offset_unit #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               switch_evt,
  input  logic               buildout_evt,
  input  logic [PHASE_W-1:0] phase_err_in,
  output logic [PHASE_W-1:0] phase_offset,
  output logic [PHASE_W-1:0] phase_err_out
);
  function automatic logic [PHASE_W-1:0] remove_offset(
    input logic [PHASE_W-1:0] raw, input logic [PHASE_W-1:0] off);
    return raw - off;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_offset <= '0;
    else if (buildout_evt) phase_offset <= phase_err_in;
    else if (switch_evt)   phase_offset <= '0;
  end

  assign phase_err_out = remove_offset(phase_err_in, phase_offset);

  AST_OFFSET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    buildout_evt |=> (phase_offset == $past(phase_err_in))); // R8
  AST_OFFSET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_evt && !buildout_evt) |=> (phase_offset == '0)); // R8
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_evt |=> $stable(phase_offset)); // R8
endmodule

// File: rtl/ref_switch_ctrl.sv
module ref_switch_ctrl
  import ref_switch_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int PHASE_W = 16,
  localparam int IDX_W  = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_valid,
  input  logic               switch_req,
  input  logic               prio_we,
  input  logic [IDX_W-1:0]   prio_widx,
  input  logic [PRIO_W-1:0]  prio_wdata,
  input  logic               thr_we,
  input  logic [PRIO_W-1:0]  thr_wdata,
  input  logic [PHASE_W-1:0] phase_err_in,
  output logic [IDX_W-1:0]   sel_ref,
  output logic               holdover,
  output logic               switch_pulse,
  output logic               buildout_pulse,
  output logic [PHASE_W-1:0] phase_offset,
  output logic [PHASE_W-1:0] phase_err_out
);
  prio_t            prio_q [NUM_REF];
  prio_t            thr_q;
  logic [IDX_W-1:0] win_idx;
  prio_t            win_prio;
  logic             win_found;
  logic             switch_evt, buildout_evt;

  ref_profile_regs #(.NUM_REF(NUM_REF), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .prio_we(prio_we), .prio_widx(prio_widx),
    .prio_wdata(prio_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .prio_q(prio_q), .thr_q(thr_q));

  ref_arbiter #(.NUM_REF(NUM_REF), .IDX_W(IDX_W)) u_arb (
    .ref_valid(ref_valid), .prio_q(prio_q), .win_idx(win_idx),
    .win_prio(win_prio), .win_found(win_found));

  ref_switch_seq #(.NUM_REF(NUM_REF), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .switch_req(switch_req),
    .prio_q(prio_q), .thr_q(thr_q), .win_idx(win_idx), .win_prio(win_prio),
    .win_found(win_found), .sel_q(sel_ref), .hold_q(holdover),
    .switch_q(switch_pulse), .buildout_q(buildout_pulse),
    .switch_evt(switch_evt), .buildout_evt(buildout_evt));

  phase_offset_unit #(.PHASE_W(PHASE_W)) u_off (
    .clk(clk), .rst_n(rst_n), .switch_evt(switch_evt),
    .buildout_evt(buildout_evt), .phase_err_in(phase_err_in),
    .phase_offset(phase_offset), .phase_err_out(phase_err_out));

  AST_WINNER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    win_found |-> ref_valid[win_idx]); // R2
  AST_SWITCH_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> $past(ref_valid[win_idx])); // R2
endmodule

// File: tb/ref_switch_ctrl_tb.sv
module ref_switch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] ref_valid = '0;
  logic          switch_req = 1'b0;
  logic          prio_we = 1'b0;
  logic [1:0]    prio_widx = '0;
  logic [2:0]    prio_wdata = '0;
  logic          thr_we = 1'b0;
  logic [2:0]    thr_wdata = '0;
  logic [PW-1:0] phase_err_in = '0;
  logic [1:0]    sel_ref;
  logic          holdover, switch_pulse, buildout_pulse;
  logic [PW-1:0] phase_offset, phase_err_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the architectural state
  int         m_sel = 0;
  bit         m_hold = 1;
  bit         m_sw = 0, m_bo = 0;
  logic [2:0] m_thr = '0;
  logic [2:0] m_prio [NR];
  logic [PW-1:0] m_off = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_switch_ctrl #(.NUM_REF(NR), .PHASE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .switch_req(switch_req),
    .prio_we(prio_we), .prio_widx(prio_widx), .prio_wdata(prio_wdata),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .phase_err_in(phase_err_in),
    .sel_ref(sel_ref), .holdover(holdover), .switch_pulse(switch_pulse),
    .buildout_pulse(buildout_pulse), .phase_offset(phase_offset),
    .phase_err_out(phase_err_out));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // lowest value wins, ties to lowest index; returns -1 when nothing is valid
  function automatic int best_ref(input logic [NR-1:0] v);
    int b = -1;
    for (int i = 0; i < NR; i++)
      if (v[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  task automatic compare_all();
    check(sel_ref == m_sel[1:0], "R2 R3 R4 R10 sel_ref", sel_ref, m_sel);
    check(holdover == m_hold, "R5 holdover", holdover, m_hold);
    check(switch_pulse == m_sw, "R11 switch_pulse", switch_pulse, m_sw);
    check(buildout_pulse == m_bo, "R6 R7 buildout_pulse", buildout_pulse, m_bo);
    check(phase_offset == m_off, "R8 phase_offset", phase_offset, m_off);
    check(phase_err_out == PW'(phase_err_in - m_off), "R9 phase_err_out",
          phase_err_out, PW'(phase_err_in - m_off));
  endtask

  // drive at negedge, update the model, compare after the next posedge
  task automatic step(input logic [NR-1:0] v, input bit req, input logic [PW-1:0] pe,
                      input bit pwe, input int pidx, input logic [2:0] pd,
                      input bit twe, input logic [2:0] td);
    int  w;
    bit  lost, better, forced, acquire, sw;
    ref_valid = v; switch_req = req; phase_err_in = pe;
    prio_we = pwe; prio_widx = pidx[1:0]; prio_wdata = pd;
    thr_we = twe; thr_wdata = td;
    w       = best_ref(v);
    lost    = !m_hold && !v[m_sel];
    better  = !m_hold && v[m_sel] && (w >= 0) && (m_prio[w] < m_prio[m_sel]);
    forced  = req && (w >= 0) && (m_hold || w != m_sel);
    acquire = m_hold && (w >= 0);
    sw      = (w >= 0) && (lost || better || forced || acquire);
    m_sw = sw;
    m_bo = sw && !(m_prio[w] < m_thr);
    if (sw) begin
      m_sel = w; m_hold = 0;
      m_off = m_bo ? pe : '0;
    end else if (lost) m_hold = 1;
    if (pwe) m_prio[pidx] = pd;
    if (twe) m_thr = td;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [NR-1:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NR; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sel_ref == 0, "R1 sel_ref", sel_ref, 0);
    check(holdover == 1, "R1 holdover", holdover, 1);
    check(!switch_pulse && !buildout_pulse, "R1 pulses", {switch_pulse, buildout_pulse}, 0);
    check(phase_offset == 0, "R1 phase_offset", phase_offset, 0);

    // R7: threshold 0, first acquisition is a build-out
    step(4'b0010, 0, 16'h1234, 0, 0, 0, 0, 0);
    check(buildout_pulse && sel_ref == 1, "R7 acquire build-out", buildout_pulse, 1);
    // R10: priorities ref1=3, ref2=1
    step(4'b0010, 0, 16'h0100, 1, 1, 3'd3, 0, 0);
    step(4'b0010, 0, 16'h0101, 1, 2, 3'd1, 0, 0);
    // R3: better ref appears
    step(4'b0110, 0, 16'h0200, 0, 0, 0, 0, 0);
    check(sel_ref == 2, "R3 better priority switch", sel_ref, 2);
    // R3 tie: ref0 priority 1 equals active -> no automatic switch
    step(4'b0110, 0, 16'h0300, 1, 0, 3'd1, 0, 0);
    step(4'b0111, 0, 16'h0301, 0, 0, 0, 0, 0);
    check(sel_ref == 2 && !switch_pulse, "R3 tie keeps active", sel_ref, 2);
    // R4: request moves to tie winner (lowest index)
    step(4'b0111, 1, 16'h0400, 0, 0, 0, 0, 0);
    check(sel_ref == 0, "R4 forced tie move", sel_ref, 0);
    // R6: threshold 2 makes ref2 (prio 1) a phase master
    step(4'b0111, 0, 16'h0500, 0, 0, 0, 1, 3'd2);
    step(4'b0110, 0, 16'h0555, 0, 0, 0, 0, 0);
    check(sel_ref == 2 && switch_pulse && !buildout_pulse, "R6 master no build-out",
          buildout_pulse, 0);
    check(phase_offset == 0, "R8 offset cleared", phase_offset, 0);
    // R5: holdover keeps selection
    step(4'b0000, 0, 16'h0600, 0, 0, 0, 0, 0);
    step(4'b0000, 0, 16'h0601, 0, 0, 0, 0, 0);
    check(holdover && sel_ref == 2, "R5 holdover keeps sel", sel_ref, 2);
    // R6: ref1 prio 3 >= thr 2 -> build-out on exit from holdover
    step(4'b0010, 0, 16'h0777, 0, 0, 0, 0, 0);
    check(!holdover && buildout_pulse && phase_offset == 16'h0777, "R5 R8 exit build-out",
          phase_offset, 16'h0777);

    // constrained random phase
    v = 4'b0010;
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < NR; b++) if ($urandom_range(7) == 0) v[b] = ~v[b];
      step(v, $urandom_range(9) == 0, PW'($urandom),
           $urandom_range(9) == 0, $urandom_range(NR - 1), 3'($urandom),
           $urandom_range(19) == 0, 3'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule